// File: doc/BRIEF.md
# Multiplexed External Memory Bus Controller

This block turns single-cycle requests from an internal master into bus cycles on an external 8-bit memory bus. The low address byte and the data share one set of lines. Every mapped cycle therefore starts with a latch phase: the controller drives the low address byte and raises a latch strobe so that an external transparent latch can hold the byte. A short hold phase follows. The shared lines then carry data. The controller drives them for a write and releases them for a read. The within-device upper address bits sit on their own pins for the whole cycle.

The two address bits above a 32K-byte window are decoded into active-low, one-hot chip selects for up to three devices. The read strobe goes to the memories' output enables and the write strobe to their write enables. Each phase length is a parameter counted in system clocks, so the strobe width, address setup and data overlap can be set to meet the memory timing at a given clock rate. The master pulses a start for one cycle and waits for a one-cycle completion pulse. Read data is held on a response port until the next read completes.

Top module: `xbus_ctrl`

## Requirements
- R1: While reset is held, all chip selects are high, both strobes are high, the latch strobe is low, the shared-bus output enable is low and the completion pulse is low.
- R2: A mapped request taken in cycle n causes two phases. The latch strobe is high for exactly ALE_CYC cycles, starting in cycle n+1 unless R9 delays it. HOLD_CYC cycles follow with the latch strobe low. In both phases the shared bus is driven with address bits 7..0.
- R3: Address bits 14..8 of the request appear on the upper address pins from the first latch cycle through the last strobe cycle.
- R4: Address bits 16:15 select the device. The values 0, 1 and 2 pull chip-select bit 0, 1 or 2 low. Exactly that bit is low during the latch, hold and strobe phases, and all bits are high at every other time.
- R5: On a write, the write strobe is low for exactly STB_CYC cycles right after the hold phase. During that time the shared bus is driven with the write data and the read strobe stays high.
- R6: On a read, the read strobe is low for exactly STB_CYC cycles right after the hold phase. During that time the shared bus is not driven. The value on the bus input in the last strobe cycle appears on the read-data port from the completion cycle onward.
- R7: The completion pulse is high for one cycle, in the cycle just after the last strobe cycle. That cycle is ALE_CYC+HOLD_CYC+STB_CYC cycles after the first latch cycle. In it, both strobes and all chip selects are high.
- R8: A request with address bits 16:15 equal to 3 makes no latch, chip-select or strobe activity. It completes in the cycle after it is taken. For a read, the read-data port shows 0xFF.
- R9: After the read strobe returns high, the shared-bus output enable stays low for at least TURN_CYC cycles, counting the cycle in which the strobe rose. A request that arrives earlier has its latch phase delayed to the first allowed cycle.
- R10: A start pulse that arrives while a bus cycle is in progress is ignored. It produces no extra bus cycle and no extra completion, and it does not change the cycle in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | One-cycle start pulse for a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Request byte address |
| req_wdata | input | 8 | Write data |
| req_ready | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Data returned by the last read |
| ad_out | output | 8 | Shared address/data bus, outgoing value |
| ad_oe | output | 1 | Shared bus output enable (tri-state control) |
| ad_in | input | 8 | Shared address/data bus, incoming value |
| addr_hi | output | 7 | Address bits 14..8 |
| ale | output | 1 | Address latch strobe, active high |
| cs_n | output | 3 | One-hot chip selects, active low |
| rd_n | output | 1 | Read strobe to memory output enable, active low |
| wr_n | output | 1 | Write strobe to memory write enable, active low |

## Verification
Each result falls in a cycle that can be computed from the request. For a start in cycle n, the first latch cycle is n+1, or, if later, the cycle of the last read-strobe rise plus TURN_CYC. Completion comes ALE_CYC+HOLD_CYC+STB_CYC cycles after that first latch cycle, or in cycle n+1 for the unmapped region. The bench numbers every cycle with its own counter and samples on falling edges. It computes each due cycle from those formulas and compares the cycle in which each event is seen. A bench memory model behind the latch and chip selects supplies read data, so a wrong address or a wrong sampling cycle shows up as wrong data.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_TURN = 3'd1,
    PH_ALE  = 3'd2,
    PH_HOLD = 3'd3,
    PH_STRB = 3'd4
  } xbus_phase_e;

  // Number of clocks a timed phase lasts.
  function automatic int unsigned phase_cycles(xbus_phase_e ph, int unsigned ale_c,
                                               int unsigned hold_c, int unsigned stb_c);
    case (ph)
      PH_ALE:  return ale_c;
      PH_HOLD: return hold_c;
      PH_STRB: return stb_c;
      default: return 1;
    endcase
  endfunction

  // Phases during which the selected device sees an active chip select.
  function automatic logic bus_phase(xbus_phase_e ph);
    return (ph == PH_ALE) || (ph == PH_HOLD) || (ph == PH_STRB);
  endfunction

  // The turnaround window has elapsed when at most one quiet cycle remains.
  function automatic logic turn_done(int unsigned gap);
    return gap <= 1;
  endfunction

endpackage

// File: rtl/xbus_decode.sv
module xbus_decode #(
  parameter int SEL_W   = 2,
  parameter int NUM_DEV = 3
) (
  input  logic [SEL_W-1:0]   sel,
  output logic [NUM_DEV-1:0] hit,
  output logic               unmapped
);

  for (genvar i = 0; i < NUM_DEV; i++) begin : g_dev
    assign hit[i] = (sel == SEL_W'(i));
  end

  assign unmapped = ~|hit;

endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
  import xbus_pkg::*;
#(
  parameter int ALE_CYC  = 2,
  parameter int HOLD_CYC = 1,
  parameter int STB_CYC  = 3,
  parameter int TURN_CYC = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        unmapped,
  input  logic        wr_q,
  output xbus_phase_e phase,
  output logic        accept,
  output logic        strobe_end,
  output logic        ready
);

  localparam int MAX_A   = (ALE_CYC > HOLD_CYC) ? ALE_CYC : HOLD_CYC;
  localparam int MAX_LEN = (MAX_A > STB_CYC) ? MAX_A : STB_CYC;
  localparam int CNT_W   = $clog2(MAX_LEN + 1);
  localparam int GAP_W   = $clog2(TURN_CYC + 1);

  xbus_phase_e      ph_q, ph_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [GAP_W-1:0] gap_q;
  logic             done_q;
  logic             gap_clear;
  logic             launch;

  function automatic logic [CNT_W-1:0] load_len(xbus_phase_e ph);
    return CNT_W'(phase_cycles(ph, ALE_CYC, HOLD_CYC, STB_CYC) - 1);
  endfunction

  assign gap_clear = turn_done(int'(gap_q));
  assign accept    = start && (ph_q == PH_IDLE);

  always_comb begin
    ph_d       = ph_q;
    cnt_d      = cnt_q;
    strobe_end = 1'b0;
    launch     = 1'b0;
    case (ph_q)
      PH_IDLE: begin
        if (accept && !unmapped) begin
          if (gap_clear) launch = 1'b1;
          else           ph_d   = PH_TURN;
        end
      end
      PH_TURN: begin
        if (gap_clear) launch = 1'b1;
      end
      PH_ALE: begin
        if (cnt_q == '0) begin
          ph_d  = PH_HOLD;
          cnt_d = load_len(PH_HOLD);
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      PH_HOLD: begin
        if (cnt_q == '0) begin
          ph_d  = PH_STRB;
          cnt_d = load_len(PH_STRB);
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      PH_STRB: begin
        if (cnt_q == '0) begin
          ph_d       = PH_IDLE;
          strobe_end = 1'b1;
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      default: ph_d = PH_IDLE;
    endcase
    if (launch) begin
      ph_d  = PH_ALE;
      cnt_d = load_len(PH_ALE);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      gap_q  <= '0;
      done_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      cnt_q  <= cnt_d;
      done_q <= strobe_end | (accept & unmapped);
      if (strobe_end && !wr_q)  gap_q <= GAP_W'(TURN_CYC);
      else if (gap_q != '0)     gap_q <= gap_q - GAP_W'(1);
    end
  end

  assign phase = ph_q;
  assign ready = done_q;

  // Checker: counts consecutive latch-phase cycles.
  logic [CNT_W:0] ale_run;
  always_ff @(posedge clk) begin
    if (!rst_n)               ale_run <= '0;
    else if (ph_q == PH_ALE)  ale_run <= ale_run + 1'b1;
    else                      ale_run <= '0;
  end

  a_r2_ale_len: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_ALE && ph_d != PH_ALE) |-> (int'(ale_run) == ALE_CYC - 1));

  a_r7_ready_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_end |=> (ready && phase == PH_IDLE));

  a_r8_unmapped_skip: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && unmapped) |=> (ready && phase == PH_IDLE));

  a_r10_busy_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (start && ph_q == PH_HOLD) |=> (ph_q == PH_HOLD || ph_q == PH_STRB));

endmodule

// File: rtl/xbus_path.sv
module xbus_path
  import xbus_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int DEV_BITS = 15,
  parameter int NUM_DEV  = 3,
  parameter int TURN_CYC = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  xbus_phase_e                phase,
  input  logic                       accept,
  input  logic                       strobe_end,
  input  logic                       unmapped,
  input  logic [NUM_DEV-1:0]         hit,
  input  logic [DEV_BITS-1:0]        req_addr,
  input  logic [DATA_W-1:0]          req_wdata,
  input  logic                       req_write,
  input  logic [DATA_W-1:0]          ad_in,
  output logic                       wr_q,
  output logic [DATA_W-1:0]          ad_out,
  output logic                       ad_oe,
  output logic [DEV_BITS-DATA_W-1:0] addr_hi,
  output logic                       ale,
  output logic [NUM_DEV-1:0]         cs_n,
  output logic                       rd_n,
  output logic                       wr_n,
  output logic [DATA_W-1:0]          rsp_rdata
);

  localparam int Q_W = $clog2(TURN_CYC + 2);

  logic [DEV_BITS-1:0] addr_q;
  logic [DATA_W-1:0]   wdata_q;
  logic [NUM_DEV-1:0]  hit_q;
  logic                addr_ph;
  logic                strobe_ph;
  logic                bus_on;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      wr_q    <= 1'b0;
      hit_q   <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      wr_q    <= req_write;
      hit_q   <= hit;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                               rsp_rdata <= '0;
    else if (strobe_end && !wr_q)             rsp_rdata <= ad_in;
    else if (accept && unmapped && !req_write) rsp_rdata <= '1;
  end

  assign addr_ph   = (phase == PH_ALE) || (phase == PH_HOLD);
  assign strobe_ph = (phase == PH_STRB);
  assign bus_on    = bus_phase(phase);

  assign ale     = (phase == PH_ALE);
  assign ad_oe   = addr_ph | (strobe_ph & wr_q);
  assign ad_out  = addr_ph ? addr_q[DATA_W-1:0] : wdata_q;
  assign rd_n    = ~(strobe_ph & ~wr_q);
  assign wr_n    = ~(strobe_ph & wr_q);
  assign cs_n    = ~(hit_q & {NUM_DEV{bus_on}});
  assign addr_hi = addr_q[DEV_BITS-1:DATA_W];

  // Checker: quiet cycles since the read strobe was last low (saturating).
  logic [Q_W-1:0] since_rd;
  always_ff @(posedge clk) begin
    if (!rst_n)                          since_rd <= Q_W'(TURN_CYC);
    else if (!rd_n)                      since_rd <= '0;
    else if (int'(since_rd) < TURN_CYC)  since_rd <= since_rd + 1'b1;
  end

  a_r9_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
    ad_oe |-> (int'(since_rd) >= TURN_CYC));

  a_r4_cs_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));

  a_r5_write_drives: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> (ad_oe && rd_n));

  a_r6_read_releases: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> (!ad_oe && wr_n));

  a_r3_hi_stable: assert property (@(posedge clk) disable iff (!rst_n)
    ((~&cs_n) && $past(~&cs_n)) |-> $stable(addr_hi));

endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
  import xbus_pkg::*;
#(
  parameter int ADDR_W   = 17,
  parameter int DATA_W   = 8,
  parameter int DEV_BITS = 15,
  parameter int NUM_DEV  = 3,
  parameter int ALE_CYC  = 2,
  parameter int HOLD_CYC = 1,
  parameter int STB_CYC  = 3,
  parameter int TURN_CYC = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  input  logic                       req_write,
  input  logic [ADDR_W-1:0]          req_addr,
  input  logic [DATA_W-1:0]          req_wdata,
  output logic                       req_ready,
  output logic [DATA_W-1:0]          rsp_rdata,
  output logic [DATA_W-1:0]          ad_out,
  output logic                       ad_oe,
  input  logic [DATA_W-1:0]          ad_in,
  output logic [DEV_BITS-DATA_W-1:0] addr_hi,
  output logic                       ale,
  output logic [NUM_DEV-1:0]         cs_n,
  output logic                       rd_n,
  output logic                       wr_n
);

  localparam int SEL_W = ADDR_W - DEV_BITS;

  xbus_phase_e        phase;
  logic               accept;
  logic               strobe_end;
  logic               unmapped;
  logic               wr_q;
  logic [NUM_DEV-1:0] hit;

  xbus_decode #(
    .SEL_W   (SEL_W),
    .NUM_DEV (NUM_DEV)
  ) u_decode (
    .sel      (req_addr[ADDR_W-1:DEV_BITS]),
    .hit      (hit),
    .unmapped (unmapped)
  );

  xbus_seq #(
    .ALE_CYC  (ALE_CYC),
    .HOLD_CYC (HOLD_CYC),
    .STB_CYC  (STB_CYC),
    .TURN_CYC (TURN_CYC)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (req_valid),
    .unmapped   (unmapped),
    .wr_q       (wr_q),
    .phase      (phase),
    .accept     (accept),
    .strobe_end (strobe_end),
    .ready      (req_ready)
  );

  xbus_path #(
    .DATA_W   (DATA_W),
    .DEV_BITS (DEV_BITS),
    .NUM_DEV  (NUM_DEV),
    .TURN_CYC (TURN_CYC)
  ) u_path (
    .clk        (clk),
    .rst_n      (rst_n),
    .phase      (phase),
    .accept     (accept),
    .strobe_end (strobe_end),
    .unmapped   (unmapped),
    .hit        (hit),
    .req_addr   (req_addr[DEV_BITS-1:0]),
    .req_wdata  (req_wdata),
    .req_write  (req_write),
    .ad_in      (ad_in),
    .wr_q       (wr_q),
    .ad_out     (ad_out),
    .ad_oe      (ad_oe),
    .addr_hi    (addr_hi),
    .ale        (ale),
    .cs_n       (cs_n),
    .rd_n       (rd_n),
    .wr_n       (wr_n),
    .rsp_rdata  (rsp_rdata)
  );

  a_r1_idle_pins: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE) |-> (&cs_n && rd_n && wr_n && !ale && !ad_oe));

endmodule

// File: tb/sim_xbus_ctrl.sv
module sim_xbus_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int A_C = 2;
  localparam int H_C = 1;
  localparam int S_C = 3;
  localparam int T_C = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [16:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready;
  logic [7:0]  rsp_rdata;
  logic [7:0]  ad_out;
  logic        ad_oe;
  logic [7:0]  ad_in = 8'h3C;
  logic [6:0]  addr_hi;
  logic        ale;
  logic [2:0]  cs_n;
  logic        rd_n;
  logic        wr_n;

  xbus_ctrl #(.ALE_CYC(A_C), .HOLD_CYC(H_C), .STB_CYC(S_C), .TURN_CYC(T_C)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rsp_rdata(rsp_rdata), .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in),
    .addr_hi(addr_hi), .ale(ale), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n));

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic        wr;
    logic [16:0] addr;
    logic [7:0]  data;
    logic [7:0]  exp_rd;
    int          issue;
    logic        unm;
  } xreq_t;

  xreq_t      exp_q[$];
  xreq_t      cur;
  xreq_t      done_it;
  logic [7:0] shadow [logic [16:0]];
  logic [7:0] ext    [logic [16:0]];
  int         n_tests = 0;
  int         n_fail  = 0;
  int         cyc = 0;
  bit         finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] pat(logic [16:0] a);
    return a[7:0] ^ {a[14:8], 1'b1} ^ {6'd0, a[16:15]};
  endfunction

  function automatic logic [1:0] dev_of(logic [2:0] c);
    case (c)
      3'b110:  return 2'd0;
      3'b101:  return 2'd1;
      3'b011:  return 2'd2;
      default: return 2'd3;
    endcase
  endfunction

  task automatic chk(string req, bit ok, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at cycle %0d: actual=0x%0h expected=0x%0h", req, cyc, act, exp);
    end
  endtask

  // Driver: pushes the expected item, pulses start, optionally pokes while busy.
  task automatic do_req(input logic wr, input logic [16:0] a, input logic [7:0] d,
                        input int poke_at);
    xreq_t it;
    it.wr    = wr;
    it.addr  = a;
    it.data  = d;
    it.unm   = (a[16:15] == 2'b11);
    it.issue = cyc;
    if (it.unm)                 it.exp_rd = 8'hFF;
    else if (shadow.exists(a))  it.exp_rd = shadow[a];
    else                        it.exp_rd = pat(a);
    if (wr && !it.unm) shadow[a] = d;
    exp_q.push_back(it);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 1; !req_ready; k++) begin
      if (k == poke_at) begin
        req_valid = 1'b1; req_write = 1'b0; req_addr = 17'h08888;
      end else begin
        req_valid = 1'b0;
      end
      @(negedge clk);
    end
    req_valid = 1'b0;
  endtask

  // Monitor and memory model, all sampled on the falling edge.
  logic [7:0]  lat_lo = '0;
  logic [16:0] mkey;
  logic        prev_ale = 0, prev_rd_n = 1, prev_oe = 0, in_op = 0;
  int          last_rd_rise = -1000;
  int          ale_first = 0, ale_run = 0, hold_run = 0, stb_run = 0, exp_first = 0;
  logic [2:0]  exp_cs;

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (ale) lat_lo = ad_out;
      mkey = {dev_of(cs_n), addr_hi, lat_lo};
      if (!wr_n) ext[mkey] = ad_out;
      if (!rd_n) ad_in = ext.exists(mkey) ? ext[mkey] : pat(mkey);
      else       ad_in = 8'h3C;

      if (rd_n && !prev_rd_n) last_rd_rise = cyc;
      if (ad_oe && !prev_oe)
        chk("R9 quiet cycles before drive", (cyc - last_rd_rise) >= T_C, cyc - last_rd_rise, T_C);

      if (ale && !prev_ale) begin
        if (exp_q.size() == 0) chk("R10 unexpected bus cycle", 1'b0, 1, 0);
        else begin
          cur = exp_q[0];
          exp_first = cur.issue + 1;
          if (last_rd_rise + T_C > exp_first) exp_first = last_rd_rise + T_C;
          chk("R2/R9 first latch cycle", cyc == exp_first, cyc, exp_first);
        end
        in_op = 1; ale_first = cyc; ale_run = 0; hold_run = 0; stb_run = 0;
      end
      if (prev_ale && !ale) chk("R2 latch length", ale_run == A_C, ale_run, A_C);

      if (in_op && !req_ready) begin
        exp_cs = ~(3'b001 << cur.addr[16:15]);
        chk("R4 chip select", cs_n == exp_cs, cs_n, exp_cs);
        chk("R3 upper address", addr_hi == cur.addr[14:8], addr_hi, cur.addr[14:8]);
        if (ale) begin
          ale_run++;
          chk("R2 address on bus", ad_oe && ad_out == cur.addr[7:0], ad_out, cur.addr[7:0]);
        end else if (rd_n && wr_n) begin
          hold_run++;
          chk("R2 address hold", ad_oe && ad_out == cur.addr[7:0], ad_out, cur.addr[7:0]);
        end else begin
          stb_run++;
          if (cur.wr)
            chk("R5 write strobe and data", !wr_n && rd_n && ad_oe && ad_out == cur.data,
                ad_out, cur.data);
          else
            chk("R6 read strobe releases bus", !rd_n && wr_n && !ad_oe, ad_oe, 0);
        end
      end

      if (req_ready) begin
        if (exp_q.size() == 0) chk("R10 unexpected completion", 1'b0, 1, 0);
        else begin
          done_it = exp_q.pop_front();
          chk("R7 pins idle at completion", &cs_n && rd_n && wr_n && !ale, {cs_n, rd_n, wr_n}, 5'h1F);
          if (done_it.unm) begin
            chk("R8 unmapped completes next cycle", cyc == done_it.issue + 1, cyc, done_it.issue + 1);
            chk("R8 unmapped makes no bus cycle", !in_op, in_op, 0);
          end else begin
            chk("R7 completion cycle", in_op && cyc == ale_first + A_C + H_C + S_C,
                cyc, ale_first + A_C + H_C + S_C);
            chk("R5/R6 strobe length", stb_run == S_C, stb_run, S_C);
            chk("R2 hold length", hold_run == H_C, hold_run, H_C);
          end
          if (!done_it.wr)
            chk(done_it.unm ? "R8 unmapped read data" : "R6 read data",
                rsp_rdata == done_it.exp_rd, rsp_rdata, done_it.exp_rd);
        end
        in_op = 0;
      end

      prev_ale = ale; prev_rd_n = rd_n; prev_oe = ad_oe;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset pins", &cs_n && rd_n && wr_n && !ale && !ad_oe && !req_ready,
        {cs_n, rd_n, wr_n, ale, ad_oe, req_ready}, 8'b11111000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    do_req(1'b1, 17'h00123, 8'h5A, 0);   // R5 write device 0
    do_req(1'b0, 17'h00123, 8'h00, 0);   // R6 read back
    do_req(1'b0, 17'h08A51, 8'h00, 0);   // R6 untouched device 1
    do_req(1'b1, 17'h17FFF, 8'hC3, 0);   // R9 write right after read, device 2 top
    do_req(1'b0, 17'h17FFF, 8'h00, 0);
    do_req(1'b0, 17'h18000, 8'h00, 0);   // R8 unmapped read
    do_req(1'b1, 17'h1ABCD, 8'h77, 0);   // R8 unmapped write
    do_req(1'b0, 17'h1FFFF, 8'h00, 0);   // R8 unmapped read, back-to-back
    do_req(1'b0, 17'h07FFF, 8'h00, 0);   // R4 device 0 boundary
    do_req(1'b1, 17'h08000, 8'hE1, 2);   // R10 start pulse while busy
    do_req(1'b0, 17'h08000, 8'h00, 4);   // R10 poke during strobe
    repeat (5) @(negedge clk);
    do_req(1'b1, 17'h10000, 8'h0F, 0);   // R9 long idle: no extra delay
    do_req(1'b0, 17'h10000, 8'h00, 0);

    repeat (8) @(negedge clk);
    chk("R10 no outstanding items", exp_q.size() == 0, exp_q.size(), 0);
    chk("R1 pins idle after traffic", &cs_n && rd_n && wr_n && !ale && !ad_oe,
        {cs_n, rd_n, wr_n, ale, ad_oe}, 7'b1111100);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule